// File: doc/BRIEF.md
# Two-Channel Sample Readout SPI Slave

This block sits on the acquisition side of a two-channel sampler. It holds captured 8-bit unsigned samples for both channels and streams them to an SPI master. In each transaction the master's first byte is a command. During that same byte the slave shifts back a status byte. After the command byte the master clocks filler bytes, and each one returns a single sample byte. The command selects one of three layouts: no data at all, a pair-interleaved stream of both channels, or a full stream of the first channel followed by the full stream of the second.

Sample storage is double-buffered. The capture side always writes into the bank that is not being read. A finished capture frame is swapped into the readout position only once the current readout bank has been read through completely and chip select is released. A readout therefore never mixes data from two captures. The SPI pins are sampled in the system clock domain through synchronizers, so the SPI clock must be much slower than the system clock.

Top module: `sample_readout_slave`

## Requirements
- R1: The SPI interface works in mode 3 with MSB first. MOSI is sampled on rising SCLK. MISO changes only after falling SCLK. Chip select is active low. Each SCLK phase lasts at least 4 system clock periods, and chip select is asserted at least 4 periods before the first falling SCLK edge.
- R2: During the command byte the slave returns a status byte. Bit 7 is 1 when the readout bank holds a frame not yet completely read. Bit 6 is 1 when a captured frame is waiting for a swap. Bit 0 is the index of the readout bank. Bits 5..1 are 0. The status is a snapshot taken when chip select is asserted. After reset the status is 0x00.
- R3: Command 0x02 returns DEPTH data bytes, interleaved as CH1[0], CH2[0], CH1[1], CH2[1], and so on (DEPTH/2 pairs).
- R4: Command 0x03 returns 2*DEPTH data bytes: CH1[0..DEPTH-1] first, then CH2[0..DEPTH-1].
- R5: Any other command value carries no data. Every byte after it returns 0x00.
- R6: Bytes clocked beyond the length that the command selected return 0x00.
- R7: Deasserting chip select at any point aborts the transaction and clears the bit and byte counters. The next transaction starts again with a command byte and data index 0. An aborted readout does not count as complete.
- R8: The capture port writes only into the bank that is not being read. cap_ch 0 selects CH1 and cap_ch 1 selects CH2. A one-cycle pulse on cap_frame_done marks the written bank as a waiting frame.
- R9: The banks swap only when three conditions hold together: a frame is waiting, the readout bank has been read completely (or reset has just occurred), and chip select is deasserted. A swap clears both the waiting flag and the completion flag.
- R10: While chip select is deasserted, MISO is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from the master, idles high |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Master-to-slave data |
| spi_miso | output | 1 | Slave-to-master data |
| cap_we | input | 1 | Capture write strobe |
| cap_ch | input | 1 | Capture channel, 0 = CH1, 1 = CH2 |
| cap_addr | input | $clog2(DEPTH) | Capture sample index |
| cap_data | input | 8 | Capture sample value |
| cap_frame_done | input | 1 | Pulse marking a complete capture frame |

## Verification
A byte counter that is off by one shows up as samples shifted by one position, or as a channel swap within the pair layout. This is visible on the first data byte of the affected transaction. Faulty ping-pong state shows up as a wrong status byte in the next transaction, or as data from an older or newer capture generation. The bench tags every sample with its capture generation, so a swap at the wrong moment is visible in the first byte read afterwards. Because the status flags, the readout data and an aborted readout followed by a re-read are all observed at MISO, no internal state goes unobserved for longer than one transaction.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

  localparam logic [7:0] CMD_PAIRS = 8'h02;
  localparam logic [7:0] CMD_SPLIT = 8'h03;

  typedef enum logic [1:0] {
    LAY_NONE  = 2'd0,
    LAY_PAIRS = 2'd1,
    LAY_SPLIT = 2'd2
  } layout_e;

  function automatic layout_e decode_cmd(input logic [7:0] cmd);
    case (cmd)
      CMD_PAIRS: return LAY_PAIRS;
      CMD_SPLIT: return LAY_SPLIT;
      default:   return LAY_NONE;
    endcase
  endfunction

  function automatic logic [7:0] make_status(input logic unread, input logic waiting,
                                              input logic bank);
    return {unread, waiting, 5'b00000, bank};
  endfunction

endpackage

// File: rtl/rdo_spi_front.sv
module rdo_spi_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel,
  output logic sel_start,
  output logic mosi_bit
);
  // bit order {mosi, cs_n, sclk}; idle levels used at reset
  localparam logic [2:0] IDLE_LVL = 3'b011;

  logic [STAGES-1:0][2:0] stage_q;
  logic [2:0]             prev_q;
  logic [2:0]             cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{IDLE_LVL}};
      prev_q  <= IDLE_LVL;
    end else begin
      stage_q[0] <= {spi_mosi, spi_cs_n, spi_sclk};
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  always_comb begin
    cur       = stage_q[STAGES-1];
    sck_rise  = cur[0] & ~prev_q[0];
    sck_fall  = ~cur[0] & prev_q[0];
    sel       = ~cur[1];
    sel_start = ~cur[1] & prev_q[1];
    mosi_bit  = cur[2];
  end

endmodule

// File: rtl/rdo_sample_bank.sv
module rdo_sample_bank #(
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wch,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic          rch,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [2*DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{wch, waddr}] <= wdata;
    if (re) rdata <= mem[{rch, raddr}];
  end

endmodule

// File: rtl/rdo_pingpong.sv
module rdo_pingpong (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_frame_done,
  input  logic readout_done,
  input  logic sel,
  output logic rd_bank,
  output logic pend,
  output logic consumed
);
  logic swap;
  logic rd_bank_d, pend_d, consumed_d;

  always_comb begin
    swap       = pend & consumed & ~sel;
    rd_bank_d  = rd_bank ^ swap;
    pend_d     = (pend & ~swap) | cap_frame_done;
    consumed_d = swap ? 1'b0 : (consumed | readout_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bank  <= 1'b0;
      pend     <= 1'b0;
      consumed <= 1'b1;
    end else begin
      rd_bank  <= rd_bank_d;
      pend     <= pend_d;
      consumed <= consumed_d;
    end
  end

endmodule

// File: rtl/rdo_xfer_ctrl.sv
module rdo_xfer_ctrl
  import rdo_pkg::*;
#(
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          sel,
  input  logic          sel_start,
  input  logic          mosi_bit,
  input  logic [7:0]    status_in,
  input  logic [7:0]    rd_data,
  output logic          rd_en,
  output logic          rd_ch,
  output logic [AW-1:0] rd_addr,
  output logic          readout_done,
  output logic          spi_miso
);
  localparam logic [CW-1:0] LEN_PAIRS = CW'(DEPTH);
  localparam logic [CW-1:0] LEN_SPLIT = CW'(2 * DEPTH);
  localparam logic [CW-1:0] CNT_MAX   = '1;

  logic [2:0]    bit_q, bit_d;
  logic [CW-1:0] byte_q, byte_d;
  layout_e       layout_q, layout_d, layout_now;
  logic [7:0]    rx_q, rx_d, rx_full;
  logic [7:0]    tx_q, tx_d;
  logic          miso_q, miso_d;
  logic          load_q, load_d;
  logic          hit_q, hit_d;
  logic          byte_done, in_range;
  logic [CW-1:0] len_now;

  // decode and read addressing for the byte that follows the one completing
  always_comb begin
    rx_full    = {rx_q[6:0], mosi_bit};
    byte_done  = sel & sck_rise & (bit_q == 3'd7);
    layout_now = (byte_q == '0) ? decode_cmd(rx_full) : layout_q;
    case (layout_now)
      LAY_PAIRS: len_now = LEN_PAIRS;
      LAY_SPLIT: len_now = LEN_SPLIT;
      default:   len_now = '0;
    endcase
    in_range = byte_q < len_now;
    rd_en    = byte_done & in_range;
    if (layout_now == LAY_SPLIT) begin
      rd_ch   = byte_q[AW];
      rd_addr = byte_q[AW-1:0];
    end else begin
      rd_ch   = byte_q[0];
      rd_addr = byte_q[AW:1];
    end
    readout_done = byte_done & (len_now != '0) & (byte_q == len_now);
  end

  // next state
  always_comb begin
    bit_d    = bit_q;
    byte_d   = byte_q;
    layout_d = layout_q;
    rx_d     = rx_q;
    tx_d     = tx_q;
    miso_d   = miso_q;
    load_d   = 1'b0;
    hit_d    = hit_q;
    if (!sel || sel_start) begin
      bit_d    = 3'd0;
      byte_d   = '0;
      layout_d = LAY_NONE;
      miso_d   = 1'b0;
      hit_d    = 1'b0;
      if (sel_start) tx_d = status_in;
    end else begin
      load_d = byte_done;
      if (byte_done) hit_d = in_range;
      if (sck_rise) begin
        rx_d  = rx_full;
        bit_d = bit_q + 3'd1;
      end
      if (byte_done) begin
        if (byte_q != CNT_MAX) byte_d = byte_q + CW'(1);
        layout_d = layout_now;
      end
      if (sck_fall) begin
        miso_d = tx_q[7];
        tx_d   = {tx_q[6:0], 1'b0};
      end
      if (load_q) tx_d = hit_q ? rd_data : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q    <= 3'd0;
      byte_q   <= '0;
      layout_q <= LAY_NONE;
      rx_q     <= 8'h00;
      tx_q     <= 8'h00;
      miso_q   <= 1'b0;
      load_q   <= 1'b0;
      hit_q    <= 1'b0;
    end else begin
      bit_q    <= bit_d;
      byte_q   <= byte_d;
      layout_q <= layout_d;
      rx_q     <= rx_d;
      tx_q     <= tx_d;
      miso_q   <= miso_d;
      load_q   <= load_d;
      hit_q    <= hit_d;
    end
  end

  assign spi_miso = miso_q;

endmodule

// File: rtl/sample_readout_slave.sv
module sample_readout_slave
  import rdo_pkg::*;
#(
  parameter  int DEPTH       = 1024,
  parameter  int SYNC_STAGES = 2,
  localparam int AW          = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  input  logic          cap_we,
  input  logic          cap_ch,
  input  logic [AW-1:0] cap_addr,
  input  logic [7:0]    cap_data,
  input  logic          cap_frame_done
);
  logic          sck_rise, sck_fall, sel, sel_start, mosi_bit;
  logic          rd_bank, pend, consumed, readout_done;
  logic          rd_en, rd_ch;
  logic [AW-1:0] rd_addr;
  logic [7:0]    status, rd_data;
  logic [7:0]    bank_rd [2];

  rdo_spi_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n),
    .spi_mosi  (spi_mosi),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .sel       (sel),
    .sel_start (sel_start),
    .mosi_bit  (mosi_bit)
  );

  rdo_pingpong u_pp (
    .clk            (clk),
    .rst_n          (rst_n),
    .cap_frame_done (cap_frame_done),
    .readout_done   (readout_done),
    .sel            (sel),
    .rd_bank        (rd_bank),
    .pend           (pend),
    .consumed       (consumed)
  );

  assign status = make_status(~consumed, pend, rd_bank);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    rdo_sample_bank #(.DEPTH(DEPTH)) u_bank (
      .clk   (clk),
      .we    (cap_we & (rd_bank != 1'(b))),
      .wch   (cap_ch),
      .waddr (cap_addr),
      .wdata (cap_data),
      .re    (rd_en & (rd_bank == 1'(b))),
      .rch   (rd_ch),
      .raddr (rd_addr),
      .rdata (bank_rd[b])
    );
  end

  assign rd_data = bank_rd[rd_bank];

  rdo_xfer_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .sck_rise     (sck_rise),
    .sck_fall     (sck_fall),
    .sel          (sel),
    .sel_start    (sel_start),
    .mosi_bit     (mosi_bit),
    .status_in    (status),
    .rd_data      (rd_data),
    .rd_en        (rd_en),
    .rd_ch        (rd_ch),
    .rd_addr      (rd_addr),
    .readout_done (readout_done),
    .spi_miso     (spi_miso)
  );

endmodule

// File: rtl/rdo_readout_chk.sv
module rdo_readout_chk (
  input logic clk,
  input logic rst_n,
  input logic sel,
  input logic rd_bank,
  input logic pend,
  input logic consumed,
  input logic spi_miso
);

  // R9: the readout bank never changes during a selected transaction
  a_r9_bank_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> $stable(rd_bank));

  // R9: a swap needs a waiting frame and a completed readout
  a_r9_swap_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_bank != $past(rd_bank)) |-> ($past(pend) && $past(consumed)));

  // R9: after a swap the new readout bank counts as unread
  a_r9_fresh_after_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_bank != $past(rd_bank)) |-> !consumed);

  // R7: completion is only recorded inside a transaction
  a_r7_done_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(consumed) |-> $past(sel));

  // R10: MISO quiet while deselected
  a_r10_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !$past(sel)) |-> !spi_miso);

endmodule

bind sample_readout_slave rdo_readout_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel      (sel),
  .rd_bank  (rd_bank),
  .pend     (pend),
  .consumed (consumed),
  .spi_miso (spi_miso)
);

// File: tb/sim_sample_readout_slave.sv
`timescale 1ns/1ps
module sim_sample_readout_slave;
  localparam int D  = 16;
  localparam int AW = $clog2(D);
  localparam int H  = 6;

  logic clk, rst_n;
  logic spi_sclk, spi_cs_n, spi_mosi, spi_miso;
  logic cap_we, cap_ch, cap_frame_done;
  logic [AW-1:0] cap_addr;
  logic [7:0] cap_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sample_readout_slave #(.DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .cap_we(cap_we), .cap_ch(cap_ch),
    .cap_addr(cap_addr), .cap_data(cap_data), .cap_frame_done(cap_frame_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] val(input int gen, input int ch, input int a);
    return {3'(gen), 1'(ch), 4'(a)};
  endfunction

  function automatic logic [7:0] exp_pairs(input int gen, input int k);
    return val(gen, k % 2, k / 2);
  endfunction

  function automatic logic [7:0] exp_split(input int gen, input int k);
    return val(gen, k / D, k % D);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] o, output logic [7:0] i);
    for (int b = 7; b >= 0; b--) begin
      @(negedge clk);
      spi_sclk = 1'b0;
      spi_mosi = o[b];
      repeat (H) @(negedge clk);
      i[b] = spi_miso;
      spi_sclk = 1'b1;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic cs_begin();
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_end();
    @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic load_frame(input int gen);
    for (int ch = 0; ch < 2; ch++)
      for (int a = 0; a < D; a++) begin
        @(negedge clk);
        cap_we = 1'b1; cap_ch = 1'(ch); cap_addr = AW'(a); cap_data = val(gen, ch, a);
      end
    @(negedge clk);
    cap_we = 1'b0;
    cap_frame_done = 1'b1;
    @(negedge clk);
    cap_frame_done = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    check("R10 miso idle after reset", {7'b0, spi_miso}, 8'h00);
    cs_begin();
    spi_byte(8'h00, r); check("R2 reset status", r, 8'h00);
    for (int k = 0; k < 2; k++) begin
      spi_byte(8'hFF, r); check("R5 no-data command", r, 8'h00);
    end
    cs_end();
    check("R10 miso idle after txn", {7'b0, spi_miso}, 8'h00);
  endtask

  task automatic t_normal();
    logic [7:0] r;
    load_frame(1);
    cs_begin();
    spi_byte(CMD, r); check("R2 status after swap", r, 8'h81);
    for (int k = 0; k < D; k++) begin
      spi_byte(8'hFF, r); check("R3 R1 interleaved sample", r, exp_pairs(1, k));
    end
    for (int k = 0; k < 2; k++) begin
      spi_byte(8'hFF, r); check("R6 past end", r, 8'h00);
    end
    cs_end();
    cs_begin();
    spi_byte(8'h00, r); check("R9 consumed flag", r, 8'h01);
    cs_end();
  endtask

  localparam logic [7:0] CMD = 8'h02;

  task automatic t_dual();
    logic [7:0] r;
    load_frame(2);
    cs_begin();
    spi_byte(8'h03, r); check("R9 R2 status dual", r, 8'h80);
    for (int k = 0; k < 2 * D; k++) begin
      spi_byte(8'hFF, r); check("R4 split sample", r, exp_split(2, k));
    end
    spi_byte(8'hFF, r); check("R6 past end split", r, 8'h00);
    cs_end();
  endtask

  task automatic t_abort();
    logic [7:0] r;
    load_frame(3);
    cs_begin();
    spi_byte(8'h02, r); check("R2 status before abort", r, 8'h81);
    for (int k = 0; k < 3; k++) begin
      spi_byte(8'hFF, r); check("R3 partial", r, exp_pairs(3, k));
    end
    cs_end();
    load_frame(4);
    cs_begin();
    spi_byte(8'h02, r); check("R7 R9 abort not complete", r, 8'hC1);
    for (int k = 0; k < D; k++) begin
      spi_byte(8'hFF, r); check("R7 R8 restart from index 0", r, exp_pairs(3, k));
    end
    cs_end();
    cs_begin();
    spi_byte(8'h03, r); check("R9 swap after full read", r, 8'h80);
    for (int k = 0; k < 2 * D; k++) begin
      spi_byte(8'hFF, r); check("R8 waiting frame intact", r, exp_split(4, k));
    end
    cs_end();
  endtask

  task automatic t_busy_hold();
    logic [7:0] r;
    cs_begin();
    spi_byte(8'h00, r); check("R2 status consumed", r, 8'h00);
    load_frame(5);
    spi_byte(8'hFF, r); check("R5 zero while held", r, 8'h00);
    cs_end();
    cs_begin();
    spi_byte(8'h7E, r); check("R9 swap deferred to idle", r, 8'h81);
    for (int k = 0; k < 2; k++) begin
      spi_byte(8'hFF, r); check("R5 unknown command", r, 8'h00);
    end
    cs_end();
    cs_begin();
    spi_byte(8'h02, r); check("R2 status unread", r, 8'h81);
    for (int k = 0; k < D; k++) begin
      spi_byte(8'hFF, r); check("R8 frame written while busy", r, exp_pairs(5, k));
    end
    cs_end();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    spi_sclk = 1'b1; spi_cs_n = 1'b1; spi_mosi = 1'b0;
    cap_we = 1'b0; cap_ch = 1'b0; cap_addr = '0; cap_data = 8'h00; cap_frame_done = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_normal();
    t_dual();
    t_abort();
    t_busy_hold();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule